// File: doc/BRIEF.md
# Programmable One-Shot Interval Timer

This block counts a programmed number of 0.2 ms units and then raises a timeout flag together with a single-cycle interrupt request. An internal prescaler divides the system clock down to the 0.2 ms unit. The divide ratio is worked out from two parameters: the clock frequency and the unit rate.

Software programs an 8-bit interval value n at offset 3. It then starts the timer by setting bit 0 of the control word at offset 4. Each timeout is a one-shot event. The flag stays up until software writes the enable bit back to 0. The timer counts again only after a fresh 0-to-1 transition of that bit. Every start reloads the count from n and restarts the prescaler phase, so the interval always spans exactly n whole units.

Top module: `ivt_timer`

## Requirements
- R1: After reset the timeout flag and the interrupt request are low, the enable bit reads 0 and the interval register reads 1.
- R2: A write to offset 3 stores the 8-bit interval and a read of offset 3 returns it. A read of offset 4 returns the enable in bit 0 and zeros elsewhere. Reads of any other offset return 0.
- R3: A write that takes the enable bit from 0 to 1 loads the count. The timeout flag rises exactly n × DIV clock cycles after the clock edge that accepts that write, where DIV = CLK_HZ / TICK_HZ.
- R4: An interval of 0 counts as 1 unit, and it still reads back as 0.
- R5: Once set, the timeout flag stays high while the enable bit stays 1. This holds even when the value 1 is written to the enable bit again.
- R6: Writing 0 to the enable bit clears the timeout flag at the accepting edge. It also abandons a count in progress, and no interrupt follows from it.
- R7: After a timeout the timer stops counting. No further interrupt occurs until the enable bit is cleared and set again.
- R8: The interrupt request is a one-cycle pulse in the cycle where the timeout flag rises.
- R9: A change to the interval made while a count is running does not alter that count. It takes effect at the next start.
- R10: A cycle with the write strobe low, or a write to an offset other than 3 or 4, leaves the interval and the enable unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | IVL_W | Write data |
| bus_rdata | output | IVL_W | Read data for bus_addr (combinational) |
| timeout_o | output | 1 | Timeout status flag |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with CLK_HZ = 20000 and TICK_HZ = 5000, so the divide ratio is 4. With that ratio even the longest interval of 255 units expires within about a thousand cycles, and both the shortest and longest intervals can be reached in one run. A ratio above 1 also exposes whether the prescaler phase really restarts at each start: the expected expiry cycle is exact, and the scoreboard rejects any expiry that arrives one prescaler phase early or late.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  // Register offsets decoded by the bus interface
  localparam int unsigned OFS_INTERVAL = 3;
  localparam int unsigned OFS_CTRL     = 4;

  // Interval as counted: a zero interval behaves as a single unit
  function automatic int unsigned eff_interval(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Clock cycles per timer unit, never below one
  function automatic int unsigned tick_div(input int unsigned clk_hz,
                                           input int unsigned tick_hz);
    int unsigned d;
    d = (tick_hz == 0) ? 1 : clk_hz / tick_hz;
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every_cycle
      assign tick_o = !restart_i;
    end else begin : g_divider
      localparam int unsigned PC_W = $clog2(DIV);
      localparam logic [PC_W-1:0] LAST = PC_W'(DIV - 1);
      logic [PC_W-1:0] pc_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pc_q <= '0;
        else if (restart_i)      pc_q <= '0;
        else if (pc_q == LAST)   pc_q <= '0;
        else                     pc_q <= pc_q + PC_W'(1);
      end

      assign tick_o = (pc_q == LAST) && !restart_i;

      // R3: units are at least two cycles apart when dividing
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      // R3: a restart realigns the unit phase
      a_r3_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned IVL_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [IVL_W-1:0]  wdata_i,
  output logic [IVL_W-1:0]  rdata_o,
  output logic [IVL_W-1:0]  ivl_o,
  output logic              arm_o,
  output logic              disarm_o
);

  localparam logic [ADDR_W-1:0] A_IVL  = ADDR_W'(OFS_INTERVAL);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic [IVL_W-1:0] ivl_q;
  logic             en_q;
  logic             wr_ivl, wr_ctrl;

  assign wr_ivl  = wr_i && (addr_i == A_IVL);
  assign wr_ctrl = wr_i && (addr_i == A_CTRL);

  // Named events for the counter and the assertions
  assign arm_o    = wr_ctrl &&  wdata_i[0] && !en_q;
  assign disarm_o = wr_ctrl && !wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= IVL_W'(1);
      en_q  <= 1'b0;
    end else begin
      if (wr_ivl)  ivl_q <= wdata_i;
      if (wr_ctrl) en_q  <= wdata_i[0];
    end
  end

  always_comb begin
    case (addr_i)
      A_IVL:   rdata_o = ivl_q;
      A_CTRL:  rdata_o = {{(IVL_W-1){1'b0}}, en_q};
      default: rdata_o = '0;
    endcase
  end

  assign ivl_o = ivl_q;

  // R10: an idle bus leaves both registers alone
  a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(ivl_q) && $stable(en_q)));
  // R2: a start leaves the enable set
  a_r2_arm_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> en_q);

endmodule

// File: rtl/ivt_countdown.sv
module ivt_countdown #(
  parameter int unsigned IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             disarm_i,
  input  logic             tick_i,
  input  logic [IVL_W-1:0] load_i,
  output logic             running_o,
  output logic             timeout_o,
  output logic             irq_o
);

  logic [IVL_W-1:0] cnt_q;
  logic             run_q, to_q, irq_q;
  logic             expire;

  assign expire = run_q && tick_i && (cnt_q == IVL_W'(1)) && !disarm_i && !arm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      to_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire;
      if (arm_i) begin
        cnt_q <= load_i;
        run_q <= 1'b1;
        to_q  <= 1'b0;
      end else if (disarm_i) begin
        run_q <= 1'b0;
        to_q  <= 1'b0;
      end else if (expire) begin
        run_q <= 1'b0;
        to_q  <= 1'b1;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - IVL_W'(1);
      end
    end
  end

  assign running_o = run_q;
  assign timeout_o = to_q;
  assign irq_o     = irq_q;

  // R8: the request lasts one cycle
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8: the request coincides with the flag
  a_r8_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> to_q);
  // R5: the flag holds until disabled
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !disarm_i) |=> to_q);
  // R6: disabling clears the flag and blocks any request
  a_r6_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> (!to_q && !irq_q && !run_q));
  // R7: nothing counts after a timeout
  a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> !run_q);
  // R3: a running count never reaches zero
  a_r3_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));
  // R9: between units the count is held
  a_r9_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !arm_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 5_000,
  parameter int unsigned IVL_W   = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [IVL_W-1:0]  bus_wdata,
  output logic [IVL_W-1:0]  bus_rdata,
  output logic              timeout_o,
  output logic              irq_o
);

  localparam int unsigned DIV = tick_div(CLK_HZ, TICK_HZ);

  logic [IVL_W-1:0] ivl;
  logic [IVL_W-1:0] load_val;
  logic             arm_evt, disarm_evt, tick, running;

  ivt_regs #(.IVL_W(IVL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr),
    .wr_i     (bus_wr),
    .wdata_i  (bus_wdata),
    .rdata_o  (bus_rdata),
    .ivl_o    (ivl),
    .arm_o    (arm_evt),
    .disarm_o (disarm_evt)
  );

  assign load_val = IVL_W'(eff_interval(int'(ivl)));

  ivt_tick_gen #(.DIV(DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (arm_evt),
    .tick_o    (tick)
  );

  ivt_countdown #(.IVL_W(IVL_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_evt),
    .disarm_i  (disarm_evt),
    .tick_i    (tick),
    .load_i    (load_val),
    .running_o (running),
    .timeout_o (timeout_o),
    .irq_o     (irq_o)
  );

  // R3, R4: a start always leaves the counter running
  a_r4_arm_runs: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> running);
  // R7: a request only follows a running count
  a_r7_irq_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(running));

endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;

  localparam int unsigned CLK_HZ  = 20000;
  localparam int unsigned TICK_HZ = 5000;
  localparam int          DIV     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       timeout_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit prev_irq = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  ivt_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timeout_o(timeout_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int units(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Start the timer; the driver queues the expected expiry cycle
  task automatic start(input int n, input bit expect_irq);
    @(negedge clk);
    bus_addr = 3'd4; bus_wdata = 8'h01; bus_wr = 1'b1;
    if (expect_irq) exp_q.push_back(cyc + 1 + units(n) * DIV);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input int expv, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(int'(bus_rdata) == expv, tag, int'(bus_rdata), expv);
  endtask

  // Monitor: compares every request with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected irq at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R3 irq cycle", cyc, e);
          check(timeout_o == 1'b1, "R8 flag with irq", int'(timeout_o), 1);
        end
        if (prev_irq) check(1'b0, "R8 irq longer than one cycle", 1, 0);
      end else if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        check(1'b0, "R3 missed irq, cycle", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
      prev_irq = irq_o;
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(timeout_o == 1'b0, "R1 timeout after reset", int'(timeout_o), 0);
    check(irq_o == 1'b0, "R1 irq after reset", int'(irq_o), 0);
    rd_check(3'd3, 1, "R1 interval reset value");
    rd_check(3'd4, 0, "R1 enable reset value");

    // R2 readback
    wr(3'd3, 8'hA5);
    rd_check(3'd3, 8'hA5, "R2 interval readback");
    rd_check(3'd6, 0, "R2 unused offset reads 0");

    // R3 basic interval
    wr(3'd3, 8'd5);
    start(5, 1'b1);
    rd_check(3'd4, 1, "R2 enable readback");
    repeat (5 * DIV + 2) @(negedge clk);
    check(timeout_o == 1'b1, "R3 timeout set", int'(timeout_o), 1);

    // R5 / R7 flag holds, re-writing 1 does not restart
    repeat (40) @(negedge clk);
    check(timeout_o == 1'b1, "R5 flag held", int'(timeout_o), 1);
    wr(3'd4, 8'h01);
    repeat (40) @(negedge clk);
    check(timeout_o == 1'b1, "R5 flag held after rewrite of 1", int'(timeout_o), 1);

    // R6 clear
    wr(3'd4, 8'h00);
    check(timeout_o == 1'b0, "R6 flag cleared", int'(timeout_o), 0);

    // R4 zero interval
    wr(3'd3, 8'd0);
    rd_check(3'd3, 0, "R4 zero reads back");
    start(0, 1'b1);
    repeat (DIV + 3) @(negedge clk);
    check(timeout_o == 1'b1, "R4 zero acts as one unit", int'(timeout_o), 1);
    wr(3'd4, 8'h00);

    // R9 interval change during a count
    wr(3'd3, 8'd10);
    start(10, 1'b1);
    repeat (8) @(negedge clk);
    wr(3'd3, 8'd2);
    repeat (10 * DIV) @(negedge clk);
    check(timeout_o == 1'b1, "R9 running count unchanged", int'(timeout_o), 1);
    wr(3'd4, 8'h00);
    start(2, 1'b1);
    repeat (2 * DIV + 3) @(negedge clk);
    check(timeout_o == 1'b1, "R9 new interval used at next start", int'(timeout_o), 1);
    wr(3'd4, 8'h00);

    // R6 abort mid-count
    wr(3'd3, 8'd6);
    start(6, 1'b0);
    repeat (10) @(negedge clk);
    wr(3'd4, 8'h00);
    repeat (40) @(negedge clk);
    check(timeout_o == 1'b0, "R6 abandoned count stays quiet", int'(timeout_o), 0);

    // R10 ignored bus activity
    wr(3'd5, 8'hFF);
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'h77; bus_wr = 1'b0;
    @(negedge clk);
    rd_check(3'd3, 6, "R10 interval untouched");
    rd_check(3'd4, 0, "R10 enable untouched");
    check(timeout_o == 1'b0, "R10 no start from ignored writes", int'(timeout_o), 0);

    // R3 extremes
    wr(3'd3, 8'd1);
    start(1, 1'b1);
    repeat (DIV + 3) @(negedge clk);
    check(timeout_o == 1'b1, "R3 one unit", int'(timeout_o), 1);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'd255);
    start(255, 1'b1);
    repeat (255 * DIV + 3) @(negedge clk);
    check(timeout_o == 1'b1, "R3 255 units", int'(timeout_o), 1);
    wr(3'd4, 8'h00);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected irqs seen", exp_q.size(), 0);
    done = 1'b1;
    report();
  end

endmodule